// File: doc/BRIEF.md
# Polarity-Strapped Bank Enable Qualifier

This block decides whether one synchronous SRAM in a depth-expanded array takes part in the current cycle. It has a fixed active-low device enable and a set of bank enables whose sense is chosen by static strap inputs. A bank enable counts as asserted when its level equals its strap. When four copies are strapped 00, 01, 10 and 11 and their bank enables are driven from two high address bits, exactly one copy answers, and no decode logic is needed outside the RAMs.

Each cycle in which the load strobe is low is classified as bank-off, deselect, read or write. Cycles in which the load strobe is high continue the previous class. From that class the block produces two output-enable signals that are delayed by the same number of stages. One enables the data-bus drivers and follows reads only. The other enables the echo-clock drivers and drops only on a bank-off. Because of this, a deselect through the fixed enable floats the data bus but keeps the echo clocks running. A deselect cycle placed at a bank switch therefore lets the new bank drive its echo clock before its first read data.

Top module: `bank_gate`

## Requirements
- R1: `hit_o` is 1 exactly when every bit of `bank_en` equals the matching bit of `strap_pol`. A strap of 1 makes that enable active high, and a strap of 0 makes it active low.
- R2: At a rising edge with `ld_n`=0 and `hit_o`=0, `kind_o` becomes 00 (bank-off). This holds whatever the values of `dev_en_n` and `wr_n`.
- R3: At a rising edge with `ld_n`=0, `hit_o`=1 and `dev_en_n`=1, `kind_o` becomes 01 (deselect).
- R4: At a rising edge with `ld_n`=0, `hit_o`=1 and `dev_en_n`=0, `kind_o` becomes 10 (read) if `wr_n`=1, or 11 (write) if `wr_n`=0.
- R5: At a rising edge with `ld_n`=1, `kind_o` keeps its value. Changes on `bank_en`, `dev_en_n` and `wr_n` have no effect in that cycle.
- R6: `dq_oe` equals 1 exactly when `kind_o` was 10 (read) `OUT_LAT` rising edges earlier.
- R7: `cq_oe` equals 1 exactly when `kind_o` was not 00 (bank-off) `OUT_LAT` rising edges earlier. Because it has the same delay as `dq_oe`, `dq_oe`=1 implies `cq_oe`=1.
- R8: While `rst_n` is low, `kind_o` is 00 and both `dq_oe` and `cq_oe` are 0.
- R9: Take four copies with straps 00, 01, 10 and 11, with their bank enables driven by a 2-bit address. For every address exactly one copy has `hit_o`=1, and at most one copy has `dq_oe`=1.
- R10: Consider a read in one bank, then a deselect (`dev_en_n`=1) addressed to a second bank, then a read in the second bank. The `cq_oe` of the second bank rises at least one cycle before its `dq_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_pol | input | N_PROG | Static polarity straps, one per bank enable |
| bank_en | input | N_PROG | Bank enables, sense set by `strap_pol` |
| dev_en_n | input | 1 | Fixed active-low device enable |
| ld_n | input | 1 | Load strobe, low starts a new command and high continues the previous one |
| wr_n | input | 1 | Write select, low for write |
| hit_o | output | 1 | All bank enables match their straps (combinational) |
| kind_o | output | 2 | Registered class: 00 bank-off, 01 deselect, 10 read, 11 write |
| dq_oe | output | 1 | Data-bus driver enable, `OUT_LAT` stages after the class |
| cq_oe | output | 1 | Echo-clock driver enable, `OUT_LAT` stages after the class |

## Verification
`hit_o` is combinational and is checked in the same cycle that its inputs are applied. `kind_o` is due one rising edge after the command. `dq_oe` and `cq_oe` are due `OUT_LAT` edges after `kind_o` took the value that sets them. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares all four copies on the next falling edge, and its delay line has the same depth as `OUT_LAT`, so each result is checked in the cycle it is due. The bank-switch sequence records the cycle in which the new bank's `cq_oe` first rises and the cycle in which its `dq_oe` first rises, and it checks that the two are at least one cycle apart.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;

   typedef enum logic [1:0] {
      K_BANKOFF = 2'b00,
      K_DESEL   = 2'b01,
      K_READ    = 2'b10,
      K_WRITE   = 2'b11
   } kind_t;

   localparam int unsigned MAX_OUT_LAT = 8;

endpackage

// File: rtl/bank_gate_match.sv
module bank_gate_match #(
   parameter int unsigned N_PROG = 2
) (
   input  logic [N_PROG-1:0] strap_pol,
   input  logic [N_PROG-1:0] bank_en,
   output logic              hit
);

   logic [N_PROG-1:0] agree;

   genvar gi;
   generate
      for (gi = 0; gi < N_PROG; gi++) begin : g_bit
         // a strap of 1 makes the enable active high, a strap of 0 active low
         assign agree[gi] = (bank_en[gi] == strap_pol[gi]);
      end
   endgenerate

   assign hit = &agree;

endmodule

// File: rtl/bank_gate_class.sv
module bank_gate_class
   import bank_gate_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ld_n,
   input  logic  hit,
   input  logic  dev_en_n,
   input  logic  wr_n,
   output kind_t kind
);

   kind_t kind_nxt;

   always_comb begin
      kind_nxt = kind;
      if (!ld_n) begin
         if (!hit)          kind_nxt = K_BANKOFF;
         else if (dev_en_n) kind_nxt = K_DESEL;
         else if (wr_n)     kind_nxt = K_READ;
         else               kind_nxt = K_WRITE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kind <= K_BANKOFF;
      else        kind <= kind_nxt;
   end

endmodule

// File: rtl/bank_gate_pipe.sv
module bank_gate_pipe #(
   parameter int unsigned OUT_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dq_in,
   input  logic cq_in,
   output logic dq_out,
   output logic cq_out
);

   generate
      if (OUT_LAT == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dq_out <= 1'b0;
               cq_out <= 1'b0;
            end else begin
               dq_out <= dq_in;
               cq_out <= cq_in;
            end
         end
      end else begin : g_chain
         logic [OUT_LAT-1:0] dq_sr;
         logic [OUT_LAT-1:0] cq_sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dq_sr <= '0;
               cq_sr <= '0;
            end else begin
               dq_sr <= {dq_sr[OUT_LAT-2:0], dq_in};
               cq_sr <= {cq_sr[OUT_LAT-2:0], cq_in};
            end
         end
         assign dq_out = dq_sr[OUT_LAT-1];
         assign cq_out = cq_sr[OUT_LAT-1];
      end
   endgenerate

endmodule

// File: rtl/bank_gate.sv
module bank_gate
   import bank_gate_pkg::*;
#(
   parameter int unsigned N_PROG  = 2,
   parameter int unsigned OUT_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PROG-1:0] strap_pol,
   input  logic [N_PROG-1:0] bank_en,
   input  logic              dev_en_n,
   input  logic              ld_n,
   input  logic              wr_n,
   output logic              hit_o,
   output logic [1:0]        kind_o,
   output logic              dq_oe,
   output logic              cq_oe
);

   generate
      if (N_PROG < 1) begin : g_bad_nprog
         $error("bank_gate: N_PROG must be at least 1");
      end
      if (OUT_LAT < 1 || OUT_LAT > MAX_OUT_LAT) begin : g_bad_lat
         $error("bank_gate: OUT_LAT out of range");
      end
   endgenerate

   kind_t kind;
   logic  drive_data;
   logic  drive_echo;

   bank_gate_match #(.N_PROG(N_PROG)) u_match (
      .strap_pol (strap_pol),
      .bank_en   (bank_en),
      .hit       (hit_o)
   );

   bank_gate_class u_class (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_n     (ld_n),
      .hit      (hit_o),
      .dev_en_n (dev_en_n),
      .wr_n     (wr_n),
      .kind     (kind)
   );

   // data floats on everything except reads; echo clocks stop only on bank-off
   assign drive_data = (kind == K_READ);
   assign drive_echo = (kind != K_BANKOFF);

   bank_gate_pipe #(.OUT_LAT(OUT_LAT)) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .dq_in  (drive_data),
      .cq_in  (drive_echo),
      .dq_out (dq_oe),
      .cq_out (cq_oe)
   );

   assign kind_o = kind;

endmodule

// File: rtl/bank_gate_chk.sv
module bank_gate_chk #(
   parameter int unsigned N_PROG  = 2,
   parameter int unsigned OUT_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dev_en_n,
   input logic              ld_n,
   input logic              wr_n,
   input logic              hit_o,
   input logic [1:0]        kind_o,
   input logic              dq_oe,
   input logic              cq_oe
);

   int unsigned warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm <= 0;
      else if (warm < OUT_LAT) warm <= warm + 1;
   end

   assert_bankoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !hit_o) |=> (kind_o == 2'b00));

   assert_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && hit_o && dev_en_n) |=> (kind_o == 2'b01));

   assert_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && hit_o && !dev_en_n) |=> (kind_o == {1'b1, ~$past(wr_n)}));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_n |=> $stable(kind_o));

   assert_dq_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= OUT_LAT) |-> (dq_oe == ($past(kind_o, OUT_LAT) == 2'b10)));

   assert_cq_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= OUT_LAT) |-> (cq_oe == ($past(kind_o, OUT_LAT) != 2'b00)));

   assert_dq_needs_cq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> cq_oe);

endmodule

bind bank_gate bank_gate_chk #(.N_PROG(N_PROG), .OUT_LAT(OUT_LAT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dev_en_n (dev_en_n),
   .ld_n     (ld_n),
   .wr_n     (wr_n),
   .hit_o    (hit_o),
   .kind_o   (kind_o),
   .dq_oe    (dq_oe),
   .cq_oe    (cq_oe)
);

// File: tb/bank_gate_tb.sv
module bank_gate_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       dev_en_n = 1'b1;
   logic       ld_n = 1'b0;
   logic       wr_n = 1'b1;

   logic       hit_w  [4];
   logic [1:0] kind_w [4];
   logic       dq_w   [4];
   logic       cq_w   [4];

   int total = 0;
   int bad   = 0;
   int stepno = 0;

   int mkind [4];
   int mhist [4][LAT];
   int mout  [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   genvar gb;
   generate
      for (gb = 0; gb < 4; gb++) begin : g_bank
         logic [1:0] strap;
         assign strap = gb[1:0];
         bank_gate #(.N_PROG(2), .OUT_LAT(LAT)) u_dut (
            .clk       (clk),
            .rst_n     (rst_n),
            .strap_pol (strap),
            .bank_en   (addr),
            .dev_en_n  (dev_en_n),
            .ld_n      (ld_n),
            .wr_n      (wr_n),
            .hit_o     (hit_w[gb]),
            .kind_o    (kind_w[gb]),
            .dq_oe     (dq_w[gb]),
            .cq_oe     (cq_w[gb])
         );
      end
   endgenerate

   task automatic chk(input string tag, input int b, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s bank=%0d step=%0d act=%0d exp=%0d", tag, b, stepno, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // model: class per bank from the requirements, delay line of depth LAT
   task automatic model_edge();
      for (int b = 0; b < 4; b++) begin
         int nk;
         nk = mkind[b];
         if (!ld_n) begin
            if (int'(addr) != b) nk = 0;
            else if (dev_en_n)   nk = 1;
            else if (wr_n)       nk = 2;
            else                 nk = 3;
         end
         for (int j = LAT-1; j > 0; j--) mhist[b][j] = mhist[b][j-1];
         mhist[b][0] = mkind[b];
         mout[b]  = mhist[b][LAT-1];
         mkind[b] = nk;
      end
   endtask

   task automatic compare(input string ktag);
      int nhit, ndq;
      nhit = 0;
      ndq  = 0;
      for (int b = 0; b < 4; b++) begin
         chk("R1 hit", b, int'(hit_w[b]), (int'(addr) == b) ? 1 : 0);
         chk(ktag, b, int'(kind_w[b]), mkind[b]);
         chk("R6 dq_oe", b, int'(dq_w[b]), (mout[b] == 2) ? 1 : 0);
         chk("R7 cq_oe", b, int'(cq_w[b]), (mout[b] != 0) ? 1 : 0);
         nhit += int'(hit_w[b]);
         ndq  += int'(dq_w[b]);
      end
      chk("R9 one hit", -1, nhit, 1);
      chk("R9 dq at most one", -1, (ndq <= 1) ? 1 : 0, 1);
   endtask

   // inputs applied after a falling edge, checked on the next falling edge
   task automatic step(input int a, input bit en_n, input bit ld, input bit w);
      string ktag;
      addr = a[1:0];
      dev_en_n = en_n;
      ld_n = ld;
      wr_n = w;
      if (ld)          ktag = "R5 kind hold";
      else if (en_n)   ktag = "R3/R2 kind";
      else             ktag = "R4/R2 kind";
      @(posedge clk);
      model_edge();
      @(negedge clk);
      stepno++;
      compare(ktag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      finish_run();
   end

   initial begin
      int cq_first, dq_first;
      for (int b = 0; b < 4; b++) begin
         mkind[b] = 0;
         mout[b]  = 0;
         for (int j = 0; j < LAT; j++) mhist[b][j] = 0;
      end
      repeat (3) @(negedge clk);
      for (int b = 0; b < 4; b++) begin
         chk("R8 reset kind", b, int'(kind_w[b]), 0);
         chk("R8 reset dq", b, int'(dq_w[b]), 0);
         chk("R8 reset cq", b, int'(cq_w[b]), 0);
      end
      rst_n = 1'b1;

      // every address against every load class, then continue with noise
      for (int a = 0; a < 4; a++) begin
         step(a, 1'b0, 1'b0, 1'b1);
         step(a, 1'b0, 1'b1, 1'b0);
         step((a + 1) % 4, 1'b1, 1'b1, 1'b0);
         step(a, 1'b0, 1'b0, 1'b0);
         step(a, 1'b1, 1'b0, 1'b1);
         step((a + 2) % 4, 1'b0, 1'b0, 1'b1);
         step(a, 1'b0, 1'b1, 1'b1);
      end

      // R10: read bank 1, deselect addressed to bank 2, read bank 2
      for (int i = 0; i < 4; i++) step(1, 1'b0, 1'b0, 1'b1);
      cq_first = -1;
      dq_first = -1;
      step(2, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 6; i++) begin
         if (cq_w[2] && cq_first < 0) cq_first = i;
         if (dq_w[2] && dq_first < 0) dq_first = i;
         step(2, 1'b0, (i == 0) ? 1'b0 : 1'b1, 1'b1);
      end
      chk("R10 cq before dq", 2, (cq_first >= 0 && dq_first > cq_first) ? 1 : 0, 1);

      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom;
         step(r & 3, r[2], r[3] & r[4], r[5]);
      end

      finish_run();
   end

endmodule